// File: doc/BRIEF.md
# Multi-Master I2C Byte Engine

This block is the master side of an I2C controller that can share its bus with other masters. It moves one byte for each host command over open-drain SCL and SDA lines. It drives those lines through two drive-low enables, and it reads SDA back through a sampled input. A command can put a START in front of the byte and a STOP after it. Without a STOP, SCL is held low and the bus is kept for the next command. A transmit byte is shifted out MSB first, and the block then reads the acknowledge in the ninth clock. A receive byte is shifted in MSB first, and the block then drives ACK or NAK in the ninth clock, as selected by the host.

Each SCL phase lasts `PHASE_CLKS` system clocks. SDA is sampled at the rising edge of SCL. SDA moves one system clock after the falling edge of SCL. While the block transmits, it compares every address and data bit that it releases with the level it reads back. If it released the line but reads a low, another master has won. The block then lets go of both lines until the byte slot ends, raises the arbitration-lost flag and returns to slave-receive. If the receiver leaves SDA high in the acknowledge slot of a transmitted byte, the block sets the bus-error flag, issues a STOP by itself and goes idle.

Top module: `i2c_byte_master`

## Requirements
- R1: A command accepted in idle, or a command with `cmd_start` set, first produces a START: SDA falls while SCL is released, and then the first data bit follows.
- R2: Every SCL high phase lasts `PHASE_CLKS` clocks. While SCL stays released, SDA changes only for a START (falling) or a STOP (rising).
- R3: A transmit byte appears on SDA MSB first, one bit for each SCL pulse, in the eight pulses before the acknowledge pulse. `rx_data` then holds the same byte as read back from the line.
- R4: In transmit, the block releases SDA in the ninth pulse. An ACK (SDA low at that rising edge) gives a one-clock `byte_done` and leaves `bus_err` clear. Without `cmd_stop`, the block then idles with SCL held low (`scl_drive_low`=1) and `busy`=0.
- R5: In transmit, SDA high in the ninth pulse sets `bus_err` and is followed by a STOP that the host did not request, after which both lines are released.
- R6: A receive byte (`cmd_read`=1) is sampled MSB first with SDA released in the data pulses. It is presented on `rx_data` at `byte_done`.
- R7: In receive, the ninth pulse carries SDA low when `ack_nak_sel`=0 (ACK) and SDA released when `ack_nak_sel`=1 (NAK). A NAK never sets `bus_err`.
- R8: With `cmd_stop` set, a normally completed byte is followed by a STOP (SDA rises while SCL is released), and the block ends with both drivers off.
- R9: If the block releases SDA for an address or data bit and samples it low, `arb_lost` is set. Both drivers stay off to the end of the byte slot, including the acknowledge pulse, and no `byte_done` is given. The block then idles with `slave_rx`=1 until the next command is accepted.
- R10: Driving a 0, or releasing for a 1 and reading 1, never counts as a loss, even when another device pulls the same zero bits.
- R11: `bus_err` and `arb_lost` remain set until a pulse on `clr_bus_err` or `clr_arb_lost` respectively.
- R12: A `go` pulse while `busy`=1 is ignored; the byte in flight completes with its own data and direction.
- R13: `irq` equals `irq_en` AND (`bus_err` OR `arb_lost`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| go | input | 1 | One-clock command pulse, accepted only when not busy |
| cmd_start | input | 1 | Send START (or repeated START) before the byte |
| cmd_stop | input | 1 | Send STOP after the byte |
| cmd_read | input | 1 | 1 = receive a byte, 0 = transmit `tx_data` |
| ack_nak_sel | input | 1 | Receive acknowledge level: 0 = ACK, 1 = NAK |
| tx_data | input | BYTE_W | Byte to transmit (address with R/W, or data) |
| irq_en | input | 1 | Interrupt enable |
| clr_bus_err | input | 1 | Clear pulse for `bus_err` |
| clr_arb_lost | input | 1 | Clear pulse for `arb_lost` |
| sda_in | input | 1 | Sampled SDA line level |
| scl_drive_low | output | 1 | 1 pulls SCL low |
| sda_drive_low | output | 1 | 1 pulls SDA low |
| busy | output | 1 | Byte slot, START or STOP in progress |
| byte_done | output | 1 | One-clock pulse at normal end of a byte |
| rx_data | output | BYTE_W | Byte read back or received |
| bus_err | output | 1 | Sticky: missing ACK in transmit |
| arb_lost | output | 1 | Sticky: arbitration lost |
| slave_rx | output | 1 | Fell back to slave-receive after a loss |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that nothing outside the block drives SDA into a START-like or STOP-like edge while the block holds SCL released inside its own byte slot. They also assume that `sda_in` is the wired-AND of the block's own drive and the other devices on the bus, with no clock stretching and `PHASE_CLKS` of at least 2. The bench builds `sda_in` in exactly that way. Its responder changes its pull only half a clock after it sees SCL fall, and in the arbitration case it pulls only in a low phase. It issues commands only at falling clock edges and clears flags only while the block is idle.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
    typedef enum logic [3:0] {
        ST_IDLE  = 4'd0,
        ST_HOLD  = 4'd1,
        ST_STA_A = 4'd2,
        ST_STA_B = 4'd3,
        ST_STA_C = 4'd4,
        ST_LO    = 4'd5,
        ST_HI    = 4'd6,
        ST_STO_A = 4'd7,
        ST_STO_B = 4'd8,
        ST_STO_C = 4'd9
    } i2cm_state_e;
endpackage

// File: rtl/i2cm_phase_timer.sv
module i2cm_phase_timer #(
    parameter int PHASE_CLKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (PHASE_CLKS > 2) ? $clog2(PHASE_CLKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(PHASE_CLKS - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run || cnt_q == LAST) cnt_d = '0;
        else                       cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = run && (cnt_q == LAST);

    initial begin
        if (PHASE_CLKS < 2) $error("PHASE_CLKS must be at least 2");
    end
endmodule

// File: rtl/i2cm_sticky_flag.sv
module i2cm_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr) flag_d = 1'b0;
        if (set) flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;

    p_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr) |=> flag_q);
    p_flag_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !flag_q);
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
    import i2cm_pkg::*;
#(
    parameter int PHASE_CLKS = 16,
    parameter int BYTE_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic              cmd_read,
    input  logic              ack_nak_sel,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              irq_en,
    input  logic              clr_bus_err,
    input  logic              clr_arb_lost,
    input  logic              sda_in,
    output logic              scl_drive_low,
    output logic              sda_drive_low,
    output logic              busy,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_data,
    output logic              bus_err,
    output logic              arb_lost,
    output logic              slave_rx,
    output logic              irq
);
    localparam int IDX_W = $clog2(BYTE_W + 1);
    localparam logic [IDX_W-1:0] FIRST_IDX = IDX_W'(BYTE_W);

    typedef struct packed {
        i2cm_state_e       st;
        logic [IDX_W-1:0]  idx;     // BYTE_W..1 data bits, 0 acknowledge slot
        logic [BYTE_W-1:0] sh;
        logic [BYTE_W-1:0] rx;
        logic              rd;
        logic              stp;
        logic              an;
        logic              lost;
        logic              samp;
        logic              scl_lo;
        logic              sda_lo;
        logic              done;
        logic              srx;
    } regs_t;

    regs_t r_d, r_q;
    logic  tick, run, be_set, al_set;

    assign run = !(r_q.st == ST_IDLE || r_q.st == ST_HOLD);

    i2cm_phase_timer #(.PHASE_CLKS(PHASE_CLKS)) timer_i (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        be_set   = 1'b0;
        al_set   = 1'b0;
        case (r_q.st)
            ST_IDLE, ST_HOLD: begin
                if (go) begin
                    r_d.sh   = tx_data;
                    r_d.rd   = cmd_read;
                    r_d.stp  = cmd_stop;
                    r_d.an   = ack_nak_sel;
                    r_d.idx  = FIRST_IDX;
                    r_d.lost = 1'b0;
                    r_d.srx  = 1'b0;
                    r_d.st   = (cmd_start || r_q.st == ST_IDLE) ? ST_STA_A : ST_LO;
                end
            end
            ST_STA_A: if (tick) r_d.st = ST_STA_B;
            ST_STA_B: if (tick) r_d.st = ST_STA_C;
            ST_STA_C: if (tick) r_d.st = ST_LO;
            ST_LO: begin
                if (tick) begin
                    r_d.st   = ST_HI;
                    r_d.samp = sda_in;
                    if (!r_q.rd && r_q.idx != '0 && r_q.sh[BYTE_W-1] && !sda_in && !r_q.lost) begin
                        r_d.lost = 1'b1;
                        al_set   = 1'b1;
                    end
                end
            end
            ST_HI: begin
                if (tick) begin
                    if (r_q.idx != '0) begin
                        r_d.idx = r_q.idx - 1'b1;
                        r_d.sh  = {r_q.sh[BYTE_W-2:0], r_q.samp};
                        r_d.st  = ST_LO;
                    end else if (r_q.lost) begin
                        r_d.st   = ST_IDLE;
                        r_d.srx  = 1'b1;
                        r_d.lost = 1'b0;
                    end else begin
                        r_d.done = 1'b1;
                        r_d.rx   = r_q.sh;
                        if (!r_q.rd && r_q.samp) begin
                            be_set  = 1'b1;
                            r_d.st  = ST_STO_A;
                        end else begin
                            r_d.st  = r_q.stp ? ST_STO_A : ST_HOLD;
                        end
                    end
                end
            end
            ST_STO_A: if (tick) r_d.st = ST_STO_B;
            ST_STO_B: if (tick) r_d.st = ST_STO_C;
            ST_STO_C: if (tick) r_d.st = ST_IDLE;
            default:  r_d.st = ST_IDLE;
        endcase

        // SCL follows the next state; SDA follows the present one, one clock later
        case (r_d.st)
            ST_HOLD, ST_STA_A, ST_STO_A: r_d.scl_lo = 1'b1;
            ST_LO:                       r_d.scl_lo = !r_d.lost;
            default:                     r_d.scl_lo = 1'b0;
        endcase
        case (r_q.st)
            ST_STA_C, ST_STO_A, ST_STO_B: r_d.sda_lo = 1'b1;
            ST_LO, ST_HI: begin
                if (r_q.lost)            r_d.sda_lo = 1'b0;
                else if (r_q.idx == '0)  r_d.sda_lo = r_q.rd && !r_q.an;
                else                     r_d.sda_lo = !r_q.rd && !r_q.sh[BYTE_W-1];
            end
            default:                      r_d.sda_lo = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    i2cm_sticky_flag berr_i (
        .clk(clk), .rst_n(rst_n), .set(be_set), .clr(clr_bus_err), .flag(bus_err)
    );
    i2cm_sticky_flag alost_i (
        .clk(clk), .rst_n(rst_n), .set(al_set), .clr(clr_arb_lost), .flag(arb_lost)
    );

    assign scl_drive_low = r_q.scl_lo;
    assign sda_drive_low = r_q.sda_lo;
    assign busy          = run;
    assign byte_done     = r_q.done;
    assign rx_data       = r_q.rx;
    assign slave_rx      = r_q.srx;
    assign irq           = irq_en && (bus_err || arb_lost);

    // SDA may move under a released SCL only as START or STOP
    p_sda_quiet_scl_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_q.scl_lo && !$past(r_q.scl_lo) && (r_q.sda_lo != $past(r_q.sda_lo)))
        |-> (r_q.st == ST_STA_C || r_q.st == ST_STO_C));
    p_ack_released_tx_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_HI && r_q.idx == '0 && !r_q.rd && !r_q.lost) |-> !sda_drive_low);
    p_lost_lines_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.lost |-> (!scl_drive_low && !sda_drive_low));
    p_lost_no_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arb_lost) |-> !byte_done);
    p_nak_rx_no_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && r_q.rd) |-> !$rose(bus_err));
    p_busy_go_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && go) |=> (r_q.rd == $past(r_q.rd) && r_q.stp == $past(r_q.stp)));
endmodule

// File: tb/i2c_byte_master_tb_top.sv
module i2c_byte_master_tb_top;
    localparam int P = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic       go = 0, cmd_start = 0, cmd_stop = 0, cmd_read = 0, ack_nak_sel = 0;
    logic [7:0] tx_data = 8'h00;
    logic       irq_en = 1, clr_bus_err = 0, clr_arb_lost = 0;
    logic       scl_drive_low, sda_drive_low, busy, byte_done, bus_err, arb_lost, slave_rx, irq;
    logic [7:0] rx_data;

    logic       resp_pull = 1'b0;
    wire        sda_line = !(sda_drive_low || resp_pull);
    wire        scl_line = !scl_drive_low;

    i2c_byte_master #(.PHASE_CLKS(P), .BYTE_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .go(go), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
        .cmd_read(cmd_read), .ack_nak_sel(ack_nak_sel), .tx_data(tx_data), .irq_en(irq_en),
        .clr_bus_err(clr_bus_err), .clr_arb_lost(clr_arb_lost), .sda_in(sda_line),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low), .busy(busy),
        .byte_done(byte_done), .rx_data(rx_data), .bus_err(bus_err), .arb_lost(arb_lost),
        .slave_rx(slave_rx), .irq(irq)
    );

    int checks = 0, errors = 0;

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // bus responder: other devices, one process owns its state
    logic [8:0] pulls = '0;       // pulls[i] = pull SDA low in pulse i (0 = MSB, 8 = ack)
    int         arm_idx = 99, arm_cnt = 0;
    int         arm_seen = 0, idx = 99, start_cnt = 0, stop_cnt = 0, hi_cnt = 0, last_hi = 0;
    logic [8:0] seen = '0;
    logic       scl_prev = 1'b1, sda_prev = 1'b1;

    always @(negedge clk) begin
        if (arm_cnt != arm_seen) begin
            idx = arm_idx;
            arm_seen = arm_cnt;
        end else if (scl_prev && scl_line && sda_prev && !sda_line) begin
            idx = -1;
            start_cnt++;
        end else if (scl_prev && scl_line && !sda_prev && sda_line) begin
            stop_cnt++;
        end
        if (scl_prev && !scl_line && idx >= -1 && idx < 9) idx++;
        if (!scl_prev && scl_line && idx >= 0 && idx <= 8) seen[idx] = sda_line;
        if (scl_line) hi_cnt++;
        else begin
            if (hi_cnt != 0) last_hi = hi_cnt;
            hi_cnt = 0;
        end
        scl_prev  = scl_line;
        sda_prev  = sda_line;
        resp_pull = (idx >= 0 && idx <= 8) ? pulls[idx] : 1'b0;
    end

    // scoreboard
    typedef struct {
        logic [7:0] byte_v;
        logic       be;
        logic       ack;
        string      req;
    } exp_t;
    exp_t exp_q[$];
    int   done_cnt = 0;

    always @(negedge clk) begin
        if (rst_n && byte_done) begin
            done_cnt++;
            if (exp_q.size() == 0) chk(1'b0, "R9 unexpected byte_done", 1, 0);
            else begin
                exp_t e;
                logic [7:0] line_b;
                e = exp_q.pop_front();
                for (int i = 0; i < 8; i++) line_b[7-i] = seen[i];
                chk(rx_data == e.byte_v, {e.req, " rx_data"}, rx_data, e.byte_v);
                chk(line_b == e.byte_v, {e.req, " line bits"}, line_b, e.byte_v);
                chk(seen[8] == e.ack, {e.req, " ack level"}, seen[8], e.ack);
                chk(bus_err == e.be, {e.req, " bus_err"}, bus_err, e.be);
            end
        end
    end

    task automatic xfer(input logic s, input logic p, input logic r, input logic an,
                        input logic [7:0] d, input logic [8:0] pl,
                        input logic push, input exp_t e, input logic mid_go);
        @(negedge clk);
        pulls     = pl;
        arm_idx   = s ? 99 : 0;
        arm_cnt++;
        if (push) exp_q.push_back(e);
        @(negedge clk);
        cmd_start = s; cmd_stop = p; cmd_read = r; ack_nak_sel = an; tx_data = d; go = 1;
        @(negedge clk);
        go = 0;
        if (mid_go) begin
            repeat (6 * P) @(negedge clk);
            cmd_start = 0; cmd_stop = 0; cmd_read = 1; tx_data = 8'h00; go = 1;
            @(negedge clk);
            go = 0;
        end
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    function automatic logic [8:0] rx_pulls(input logic [7:0] b);
        logic [8:0] v = '0;
        for (int i = 0; i < 8; i++) v[i] = !b[7-i];
        return v;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        exp_t e;
        int sc, pc, dc;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!scl_drive_low && !sda_drive_low, "R1 reset lines released", {scl_drive_low, sda_drive_low}, 0);
        chk(!busy && !bus_err && !arb_lost && !irq && !slave_rx, "R13 reset status",
            {busy, bus_err, arb_lost, irq, slave_rx}, 0);

        // address write with ACK, bus kept
        sc = start_cnt; pc = stop_cnt;
        e = '{8'hA4, 1'b0, 1'b0, "R3 R4 tx addr"};
        xfer(1, 0, 0, 0, 8'hA4, 9'h100, 1, e, 0);
        chk(start_cnt == sc + 1, "R1 START seen", start_cnt, sc + 1);
        chk(stop_cnt == pc, "R4 no STOP", stop_cnt, pc);
        chk(scl_drive_low && !busy, "R4 SCL held low idle", {scl_drive_low, busy}, 2);
        chk(last_hi == P, "R2 SCL high width", last_hi, P);

        // data byte then STOP
        e = '{8'h3C, 1'b0, 1'b0, "R3 tx data"};
        xfer(0, 1, 0, 0, 8'h3C, 9'h100, 1, e, 0);
        chk(stop_cnt == pc + 1, "R8 STOP seen", stop_cnt, pc + 1);
        chk(!scl_drive_low && !sda_drive_low, "R8 lines released", {scl_drive_low, sda_drive_low}, 0);

        // read: address, ACKed byte, NAKed last byte with STOP
        e = '{8'h91, 1'b0, 1'b0, "R3 rd addr"};
        xfer(1, 0, 0, 0, 8'h91, 9'h100, 1, e, 0);
        e = '{8'h5E, 1'b0, 1'b0, "R6 R7 rx ack"};
        xfer(0, 0, 1, 0, 8'h00, rx_pulls(8'h5E), 1, e, 0);
        pc = stop_cnt;
        e = '{8'hC3, 1'b0, 1'b1, "R6 R7 rx nak"};
        xfer(0, 1, 1, 1, 8'h00, rx_pulls(8'hC3), 1, e, 0);
        chk(!bus_err, "R7 NAK no bus_err", bus_err, 0);
        chk(stop_cnt == pc + 1, "R8 STOP after read", stop_cnt, pc + 1);

        // transmit NAK
        pc = stop_cnt;
        e = '{8'h42, 1'b1, 1'b1, "R5 tx nak"};
        xfer(1, 0, 0, 0, 8'h42, 9'h000, 1, e, 0);
        chk(stop_cnt == pc + 1, "R5 auto STOP", stop_cnt, pc + 1);
        chk(!scl_drive_low && !sda_drive_low && !busy, "R5 idle released",
            {scl_drive_low, sda_drive_low, busy}, 0);
        chk(irq, "R13 irq on bus_err", irq, 1);
        repeat (20) @(negedge clk);
        chk(bus_err, "R11 bus_err sticky", bus_err, 1);
        irq_en = 0;
        @(negedge clk);
        chk(!irq, "R13 irq masked", irq, 0);
        irq_en = 1;
        clr_bus_err = 1;
        @(negedge clk);
        clr_bus_err = 0;
        @(negedge clk);
        chk(!bus_err && !irq, "R11 bus_err cleared", {bus_err, irq}, 0);

        // go while busy ignored
        e = '{8'h81, 1'b0, 1'b0, "R12 go ignored"};
        xfer(1, 1, 0, 0, 8'h81, 9'h100, 1, e, 1);
        chk(!scl_drive_low && !busy, "R12 byte finished with STOP", {scl_drive_low, busy}, 0);

        // wired-AND: another device pulls the same zeros
        e = '{8'h55, 1'b0, 1'b0, "R10 same zeros"};
        xfer(1, 1, 0, 0, 8'h55, rx_pulls(8'h55) | 9'h100, 1, e, 0);
        chk(!arb_lost, "R10 no loss", arb_lost, 0);

        // arbitration loss in second bit
        dc = done_cnt;
        @(negedge clk);
        pulls = 9'h002; arm_idx = 99; arm_cnt++;
        @(negedge clk);
        cmd_start = 1; cmd_stop = 1; cmd_read = 0; tx_data = 8'hF0; go = 1;
        @(negedge clk);
        go = 0;
        for (int k = 0; k < 40 * P && !arb_lost; k++) @(negedge clk);
        chk(arb_lost, "R9 arb_lost set", arb_lost, 1);
        repeat (3) @(negedge clk);
        chk(!scl_drive_low && !sda_drive_low, "R9 lines off early", {scl_drive_low, sda_drive_low}, 0);
        repeat (10 * P) @(negedge clk);
        chk(!scl_drive_low && !sda_drive_low, "R9 lines off late", {scl_drive_low, sda_drive_low}, 0);
        while (busy) @(negedge clk);
        @(negedge clk);
        chk(slave_rx && !busy, "R9 slave_rx idle", {slave_rx, busy}, 2);
        chk(done_cnt == dc, "R9 no byte_done", done_cnt, dc);
        chk(irq, "R13 irq on arb_lost", irq, 1);
        repeat (10) @(negedge clk);
        chk(arb_lost, "R11 arb_lost sticky", arb_lost, 1);
        clr_arb_lost = 1;
        @(negedge clk);
        clr_arb_lost = 0;
        @(negedge clk);
        chk(!arb_lost, "R11 arb_lost cleared", arb_lost, 0);

        // new command leaves slave-receive
        e = '{8'h12, 1'b0, 1'b0, "R1 restart after loss"};
        xfer(1, 1, 0, 0, 8'h12, 9'h100, 1, e, 0);
        chk(!slave_rx, "R9 slave_rx cleared", slave_rx, 0);
        chk(exp_q.size() == 0, "R4 all bytes completed", exp_q.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule